// File: doc/BRIEF.md
# Programmable CRT Sync Timing Generator

This block produces the raster timing for a character-based display. It counts character clocks across a line, scan lines within a character row and character rows within a frame. From those counts it derives a horizontal sync pulse, a vertical sync pulse, a display-enable window, a linear memory address for the character fetch and the scan-line number inside the current row.

All geometry comes from a small bank of byte-wide registers loaded through a two-step port. The first write picks a register number and the second write stores a byte into that register. A single register carries both sync widths, one nibble each, and a nibble of zero stands for sixteen. A strap input selects a variant of the block whose vertical sync is always sixteen lines long, whatever the register says.

Register values act at the next clock edge, so the geometry can be changed while the block runs.

Top module: `crt_timing_gen`

## Requirements
- R1: While reset is high and at the first sample after it, `disp_en` is 0, `mem_addr` is 0 and `row_addr` is 0. Reset clears every register and counter to 0.
- R2: A write with `wr_en`=1 and `wr_sel`=1 latches `wr_data[4:0]` as the register number. A later write with `wr_en`=1 and `wr_sel`=0 stores `wr_data` into that register. The register number persists until it is selected again. The implemented registers and the bits they keep are:
  - 0: horizontal total minus one, 8 bits
  - 1: displayed characters per line, 8 bits
  - 2: horizontal sync position, 8 bits
  - 3: sync widths, 8 bits
  - 4: vertical total minus one, bits 6:0
  - 6: displayed rows, bits 6:0
  - 7: vertical sync row, bits 6:0
  - 9: maximum scan-line number, bits 4:0
  - 12: start address high, bits 5:0
  - 13: start address low, 8 bits
- R3: `hsync` is high while the character count is at least register 2 and below register 2 plus the horizontal width. The horizontal width is bits 3:0 of register 3, with 0 read as 16.
- R4: `vsync` goes high at scan line 0 of the row numbered by register 7. It stays high for the vertical width in scan lines. The vertical width is bits 7:4 of register 3, with 0 read as 16. It is cut short if the frame ends first.
- R5: With `vs_fixed16`=1, the vertical width is 16 lines whatever bits 7:4 of register 3 hold.
- R6: The character count runs from 0 to register 0 and then returns to 0, so a line lasts register 0 plus one clocks.
- R7: The scan-line count runs from 0 to register 9, advancing at each line end. The row count runs from 0 to register 4 and advances after the last scan line. A frame therefore lasts (reg0+1)·(reg9+1)·(reg4+1) clocks.
- R8: `disp_en` is high exactly when the character count is below register 1 and the row count is below register 6.
- R9: `mem_addr` equals the current row's base address plus the character count, modulo 2^14. The base is reloaded with {reg12[5:0], reg13} at the start of each frame. On every scan line of a row the address restarts from the same base. After a row's last scan line the base grows by register 1.
- R10: `row_addr` equals the scan-line count within the current row.
- R11: Data writes while register number 5, 8, 10, 11 or 14 to 31 is selected change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register port write strobe |
| wr_sel | input | 1 | 1: write register number, 0: write register data |
| wr_data | input | 8 | Register number or data byte |
| vs_fixed16 | input | 1 | Strap: vertical sync width fixed at 16 lines |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| disp_en | output | 1 | Active display window |
| mem_addr | output | 14 | Linear character memory address |
| row_addr | output | 5 | Scan line within the character row |

## Verification
The main timing function runs under three register sets:
- Short widths (3 characters, 2 lines) on a 20-character, 24-line frame. This sets the pulse placement apart from the frame wrap.
- Zero width nibbles on a 40-character, 32-line frame. This sets the 0-means-16 rule apart from a literal zero.
- A nonzero vertical nibble with the fixed-width strap set. This shows the strap overriding the register rather than agreeing with it by coincidence.

Writes to unimplemented register numbers are followed by a re-measurement of the frame period and pulse widths to show that nothing moved. Register reprogramming happens with the counters running, so the per-clock comparison also covers geometry changes in mid-frame.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

    localparam int CHAR_W = 8;
    localparam int ROW_W  = 7;
    localparam int RA_W   = 5;
    localparam int MA_W   = 14;
    localparam int SEL_W  = 5;
    localparam int NIB_W  = 4;
    localparam int LINE_W = ROW_W + RA_W + 1;
    localparam int WID_W  = NIB_W + 1;
    localparam int HI_W   = MA_W - CHAR_W;

    localparam logic [SEL_W-1:0] IDX_HTOTAL   = SEL_W'(0);
    localparam logic [SEL_W-1:0] IDX_HDISP    = SEL_W'(1);
    localparam logic [SEL_W-1:0] IDX_HSPOS    = SEL_W'(2);
    localparam logic [SEL_W-1:0] IDX_WIDTHS   = SEL_W'(3);
    localparam logic [SEL_W-1:0] IDX_VTOTAL   = SEL_W'(4);
    localparam logic [SEL_W-1:0] IDX_VDISP    = SEL_W'(6);
    localparam logic [SEL_W-1:0] IDX_VSPOS    = SEL_W'(7);
    localparam logic [SEL_W-1:0] IDX_MAXRA    = SEL_W'(9);
    localparam logic [SEL_W-1:0] IDX_START_HI = SEL_W'(12);
    localparam logic [SEL_W-1:0] IDX_START_LO = SEL_W'(13);

    typedef struct packed {
        logic [CHAR_W-1:0] h_total;
        logic [CHAR_W-1:0] h_disp;
        logic [CHAR_W-1:0] h_sync_pos;
        logic [NIB_W-1:0]  vs_nib;
        logic [NIB_W-1:0]  hs_nib;
        logic [ROW_W-1:0]  v_total;
        logic [ROW_W-1:0]  v_disp;
        logic [ROW_W-1:0]  v_sync_row;
        logic [RA_W-1:0]   max_raster;
        logic [MA_W-1:0]   start_addr;
    } crt_regs_t;

    // A zero field stands for the full 2^NIB_W width.
    function automatic logic [WID_W-1:0] width_of(input logic [NIB_W-1:0] f);
        return (f == '0) ? WID_W'(1 << NIB_W) : {1'b0, f};
    endfunction

    function automatic logic [WID_W-1:0] vs_width_of(input logic [NIB_W-1:0] f,
                                                     input logic fixed16);
        return fixed16 ? WID_W'(1 << NIB_W) : width_of(f);
    endfunction

endpackage

// File: rtl/crt_reg_bank.sv
module crt_reg_bank
    import crt_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CHAR_W-1:0] wr_data,
    output crt_regs_t         regs
);
    logic [SEL_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= '0;
            regs <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                sel <= wr_data[SEL_W-1:0];
            end else begin
                case (sel)
                    IDX_HTOTAL:   regs.h_total    <= wr_data;
                    IDX_HDISP:    regs.h_disp     <= wr_data;
                    IDX_HSPOS:    regs.h_sync_pos <= wr_data;
                    IDX_WIDTHS: begin
                        regs.vs_nib <= wr_data[2*NIB_W-1:NIB_W];
                        regs.hs_nib <= wr_data[NIB_W-1:0];
                    end
                    IDX_VTOTAL:   regs.v_total    <= wr_data[ROW_W-1:0];
                    IDX_VDISP:    regs.v_disp     <= wr_data[ROW_W-1:0];
                    IDX_VSPOS:    regs.v_sync_row <= wr_data[ROW_W-1:0];
                    IDX_MAXRA:    regs.max_raster <= wr_data[RA_W-1:0];
                    IDX_START_HI: regs.start_addr[MA_W-1:CHAR_W] <= wr_data[HI_W-1:0];
                    IDX_START_LO: regs.start_addr[CHAR_W-1:0]    <= wr_data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/crt_horiz.sv
module crt_horiz
    import crt_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] h_total,
    output logic [CHAR_W-1:0] char_cnt,
    output logic              line_end
);
    // >= keeps the count bounded when the total is lowered mid-line.
    assign line_end = (char_cnt >= h_total);

    always_ff @(posedge clk) begin
        if (rst)           char_cnt <= '0;
        else if (line_end) char_cnt <= '0;
        else               char_cnt <= char_cnt + 1'b1;
    end
endmodule

// File: rtl/crt_vert.sv
module crt_vert
    import crt_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [RA_W-1:0]   max_raster,
    input  logic [ROW_W-1:0]  v_total,
    output logic [RA_W-1:0]   raster,
    output logic [ROW_W-1:0]  row,
    output logic [LINE_W-1:0] line_idx,
    output logic              row_end,
    output logic              frame_end
);
    assign row_end   = (raster >= max_raster);
    assign frame_end = (row >= v_total);

    always_ff @(posedge clk) begin
        if (rst) begin
            raster   <= '0;
            row      <= '0;
            line_idx <= '0;
        end else if (line_end) begin
            if (!row_end) begin
                raster   <= raster + 1'b1;
                line_idx <= line_idx + 1'b1;
            end else if (!frame_end) begin
                raster   <= '0;
                row      <= row + 1'b1;
                line_idx <= line_idx + 1'b1;
            end else begin
                raster   <= '0;
                row      <= '0;
                line_idx <= '0;
            end
        end
    end
endmodule

// File: rtl/crt_addr_gen.sv
module crt_addr_gen
    import crt_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              row_wrap,
    input  logic              frame_wrap,
    input  logic [CHAR_W-1:0] h_disp,
    input  logic [MA_W-1:0]   start_addr,
    input  logic [CHAR_W-1:0] char_cnt,
    output logic [MA_W-1:0]   mem_addr
);
    logic [MA_W-1:0] row_base;

    always_ff @(posedge clk) begin
        if (rst)             row_base <= '0;
        else if (frame_wrap) row_base <= start_addr;
        else if (row_wrap)   row_base <= row_base + MA_W'(h_disp);
    end

    assign mem_addr = row_base + MA_W'(char_cnt);
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
    import crt_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              vs_fixed16,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic [MA_W-1:0]   mem_addr,
    output logic [RA_W-1:0]   row_addr
);
    crt_regs_t         regs;
    logic [CHAR_W-1:0] hc;
    logic              line_end;
    logic [RA_W-1:0]   ra;
    logic [ROW_W-1:0]  vc;
    logic [LINE_W-1:0] lc;
    logic              row_end, frame_end;
    logic              row_wrap, frame_wrap;

    crt_reg_bank u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .regs(regs)
    );

    crt_horiz u_horiz (
        .clk(clk), .rst(rst), .h_total(regs.h_total),
        .char_cnt(hc), .line_end(line_end)
    );

    crt_vert u_vert (
        .clk(clk), .rst(rst), .line_end(line_end),
        .max_raster(regs.max_raster), .v_total(regs.v_total),
        .raster(ra), .row(vc), .line_idx(lc),
        .row_end(row_end), .frame_end(frame_end)
    );

    assign row_wrap   = line_end & row_end;
    assign frame_wrap = row_wrap & frame_end;

    crt_addr_gen u_addr (
        .clk(clk), .rst(rst), .row_wrap(row_wrap), .frame_wrap(frame_wrap),
        .h_disp(regs.h_disp), .start_addr(regs.start_addr),
        .char_cnt(hc), .mem_addr(mem_addr)
    );

    // Sync windows: [start, start + width), clipped by the wrap of the count.
    logic [WID_W-1:0]  hs_w, vs_w;
    logic [CHAR_W:0]   hs_stop;
    logic [LINE_W-1:0] vs_first;
    logic [LINE_W:0]   vs_stop;

    assign hs_w     = width_of(regs.hs_nib);
    assign vs_w     = vs_width_of(regs.vs_nib, vs_fixed16);
    assign hs_stop  = {1'b0, regs.h_sync_pos} + (CHAR_W+1)'(hs_w);
    assign vs_first = LINE_W'(regs.v_sync_row) * (LINE_W'(regs.max_raster) + LINE_W'(1));
    assign vs_stop  = {1'b0, vs_first} + (LINE_W+1)'(vs_w);

    assign hsync    = (hc >= regs.h_sync_pos) && ({1'b0, hc} < hs_stop);
    assign vsync    = (lc >= vs_first) && ({1'b0, lc} < vs_stop);
    assign disp_en  = (hc < regs.h_disp) && (vc < regs.v_disp);
    assign row_addr = ra;

    logic reg_we;
    assign reg_we = wr_en & ~wr_sel;

    // R3
    hs_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hsync) && !$past(reg_we)) |-> (hc == regs.h_sync_pos));

    // R4
    vs_fall_line_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(vsync) && !$past(reg_we) && $stable(vs_fixed16)) |-> (hc == '0));

    // R7
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (line_end && !row_end) |=> (hc == '0) && (ra == RA_W'($past(ra) + 1'b1)));

    // R9
    frame_reload_chk: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (mem_addr == $past(regs.start_addr)));

endmodule

// File: tb/crt_timing_gen_test.sv
module crt_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        vs_fixed16 = 1'b0;
    logic        hsync, vsync, disp_en;
    logic [13:0] mem_addr;
    logic [4:0]  row_addr;

    always #4 clk = ~clk;

    crt_timing_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .vs_fixed16(vs_fixed16),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .mem_addr(mem_addr), .row_addr(row_addr)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m [0:31];
    int msel = 0;
    int mhc = 0, mra = 0, mvc = 0, mlc = 0, mbase = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m[i]) m[i] = 0;
            msel = 0; mhc = 0; mra = 0; mvc = 0; mlc = 0; mbase = 0;
        end else begin
            if (mhc >= m[0]) begin
                mhc = 0;
                if (mra >= m[9]) begin
                    mra = 0;
                    if (mvc >= m[4]) begin
                        mvc = 0; mlc = 0;
                        mbase = m[12] * 256 + m[13];
                    end else begin
                        mvc++; mlc++;
                        mbase = (mbase + m[1]) % 16384;
                    end
                end else begin
                    mra++; mlc++;
                end
            end else begin
                mhc++;
            end
            if (wr_en) begin
                if (wr_sel) msel = int'(wr_data) % 32;
                else case (msel)
                    0, 1, 2, 3, 13: m[msel] = int'(wr_data);
                    4, 6, 7:        m[msel] = int'(wr_data) % 128;
                    9:              m[msel] = int'(wr_data) % 32;
                    12:             m[msel] = int'(wr_data) % 64;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- per-clock compare and measurement ----------------
    int cyc = 0;
    bit p_hs = 0, p_vs = 0, p_de = 0;
    int hs_run = 0, vs_run = 0, de_run = 0;
    int hs_rise_t = -1, vs_rise_t = -1, de_rise_t = -1;
    int meas_hs_w, meas_vs_w, meas_de_w, meas_hs_per, meas_frame, meas_hs_pos;

    task automatic clear_meas();
        meas_hs_w = -1; meas_vs_w = -1; meas_de_w = -1;
        meas_hs_per = -1; meas_frame = -1; meas_hs_pos = -1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (!rst) begin
            int hw, vw, vss;
            bit e_hs, e_vs, e_de;
            hw  = (m[3] % 16 == 0) ? 16 : m[3] % 16;
            vw  = vs_fixed16 ? 16 : ((m[3] / 16 == 0) ? 16 : m[3] / 16);
            vss = m[7] * (m[9] + 1);
            e_hs = (mhc >= m[2]) && (mhc < m[2] + hw);
            e_vs = (mlc >= vss) && (mlc < vss + vw);
            e_de = (mhc < m[1]) && (mvc < m[6]);
            check(hsync == e_hs, "R3", "hsync", int'(hsync), int'(e_hs));
            check(vsync == e_vs, vs_fixed16 ? "R5" : "R4", "vsync", int'(vsync), int'(e_vs));
            check(disp_en == e_de, "R8", "disp_en", int'(disp_en), int'(e_de));
            check(int'(mem_addr) == (mbase + mhc) % 16384, "R9", "mem_addr",
                  int'(mem_addr), (mbase + mhc) % 16384);
            check(int'(row_addr) == mra, "R10", "row_addr", int'(row_addr), mra);

            if (hsync) hs_run++;
            else if (p_hs) begin meas_hs_w = hs_run; hs_run = 0; end
            if (hsync && !p_hs) begin
                if (hs_rise_t >= 0) meas_hs_per = cyc - hs_rise_t;
                hs_rise_t = cyc;
                if (de_rise_t >= 0 && cyc - de_rise_t <= m[0]) meas_hs_pos = cyc - de_rise_t;
            end
            if (vsync) vs_run++;
            else if (p_vs) begin meas_vs_w = vs_run; vs_run = 0; end
            if (vsync && !p_vs) begin
                if (vs_rise_t >= 0) meas_frame = cyc - vs_rise_t;
                vs_rise_t = cyc;
            end
            if (disp_en) de_run++;
            else if (p_de) begin meas_de_w = de_run; de_run = 0; end
            if (disp_en && !p_de) de_rise_t = cyc;
            p_hs = hsync; p_vs = vsync; p_de = disp_en;
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input int idx, input int val);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'(idx); step();
        wr_sel = 1'b0; wr_data = 8'(val); step();
        wr_en = 1'b0; step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        clear_meas();
        rst = 1'b1;
        run(3);
        @(negedge clk);
        // R1: state during reset
        check(disp_en == 1'b0, "R1", "disp_en in reset", int'(disp_en), 0);
        check(mem_addr == 14'd0, "R1", "mem_addr in reset", int'(mem_addr), 0);
        check(row_addr == 5'd0, "R1", "row_addr in reset", int'(row_addr), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(disp_en == 1'b0, "R1", "disp_en after reset", int'(disp_en), 0);
        check(mem_addr == 14'd0, "R1", "mem_addr after reset", int'(mem_addr), 0);
        #1;

        // Set A: 20 chars, 4 lines/row, 6 rows, hs 3 chars, vs 2 lines
        wr_reg(0, 19); wr_reg(1, 14); wr_reg(2, 16); wr_reg(3, 8'h23);
        wr_reg(4, 5);  wr_reg(6, 4);  wr_reg(7, 3);  wr_reg(9, 3);
        wr_reg(12, 8'hC1); wr_reg(13, 8'h40);
        clear_meas();
        run(1600);
        check(meas_de_w == 14, "R2", "display run after writes", meas_de_w, 14);
        check(meas_hs_pos == 16, "R3", "hsync start char", meas_hs_pos, 16);
        check(meas_hs_w == 3, "R3", "hsync width", meas_hs_w, 3);
        check(meas_hs_per == 20, "R6", "line period", meas_hs_per, 20);
        check(meas_vs_w == 40, "R4", "vsync width clocks", meas_vs_w, 40);
        check(meas_frame == 480, "R7", "frame period", meas_frame, 480);

        // Set B: zero width nibbles -> 16, wider line and taller frame
        wr_reg(0, 39); wr_reg(2, 20); wr_reg(3, 8'h00); wr_reg(4, 7);
        clear_meas();
        run(4000);
        check(meas_hs_pos == 20, "R3", "hsync start char zero-width set", meas_hs_pos, 20);
        check(meas_hs_w == 16, "R3", "hsync width 0 as 16", meas_hs_w, 16);
        check(meas_vs_w == 640, "R4", "vsync width 0 as 16 lines", meas_vs_w, 640);
        check(meas_frame == 1280, "R7", "frame period set B", meas_frame, 1280);

        // Set C: strap fixes vsync at 16 lines despite nibble 2
        vs_fixed16 = 1'b1;
        wr_reg(3, 8'h25);
        clear_meas();
        run(4000);
        check(meas_hs_w == 5, "R3", "hsync width 5", meas_hs_w, 5);
        check(meas_vs_w == 640, "R5", "fixed vsync width", meas_vs_w, 640);

        // R11: unimplemented numbers must not disturb anything
        wr_reg(5, 8'hFF); wr_reg(8, 8'hFF); wr_reg(10, 8'hFF);
        wr_reg(11, 8'hFF); wr_reg(14, 8'hFF); wr_reg(20, 8'hFF); wr_reg(31, 8'h00);
        clear_meas();
        run(4000);
        check(meas_frame == 1280, "R11", "frame period after ignored writes", meas_frame, 1280);
        check(meas_hs_w == 5, "R11", "hsync width after ignored writes", meas_hs_w, 5);
        check(meas_de_w == 14, "R11", "display run after ignored writes", meas_de_w, 14);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule